// File: doc/BRIEF.md
# Round-Robin Interrupt Source Selector

The block gathers 32 peripheral interrupt request lines and an enable mask that the processor can program. A source counts as pending only when it is both requesting and enabled. Any pending source drives a single aggregated interrupt line to the processor. When the processor wants to know which source to service, it pulses a one-cycle `take` strobe. The block then picks one pending source and reports its index on a registered output.

No source has priority over another. A rotating search pointer records where the last search stopped. Each new search starts at the pointer, walks upward and wraps modulo 32. After a source is served, the pointer moves to the position just after it. As a result, a source that stays pending is served within 32 takes.

A small register port gives three kinds of access. The whole mask can be read and written. The raw request vector can be read. A single mask bit can be set or cleared by index, without disturbing the other bits.

Top module: `rr_irq_selector`

## Requirements
- R1: A source is pending when its `irq_src` bit and its mask bit are both 1. `irq_out` is the OR of all pending bits and follows its inputs combinationally in the same cycle.
- R2: While `rst` is high at a clock edge, the mask clears to all zeros, the search pointer goes to 0, `sel_valid` goes to 0 and `sel_index` goes to 0.
- R3: On a clock edge with `take`=1 and at least one source pending, the block selects the first pending index found from the pointer upward, wrapping from 31 to 0. After that edge, `sel_index` shows the selected index and `sel_valid` is 1.
- R4: After a selection, the pointer equals the selected index plus 1, modulo 32. Selecting 31 leaves the pointer at 0.
- R5: On a clock edge with `take`=1 and nothing pending, `sel_valid` becomes 0. `sel_index` and the pointer keep their values.
- R6: On edges with `take`=0, `sel_index`, `sel_valid` and the pointer keep their values, whatever the requests and the mask do.
- R7: Register address 0 (`reg_addr`=2'b00) reads the full mask. A write to it replaces the mask with `reg_wdata` from the next cycle on.
- R8: Address 1 reads the raw `irq_src` vector. A write to address 1 leaves the mask unchanged.
- R9: A write to address 2 sets mask bit `reg_wdata[4:0]`. A write to address 3 clears that bit. All other mask bits keep their values. Reads of addresses 2 and 3 return 0.
- R10: When all 32 sources stay pending, 32 consecutive takes select every index exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Raw interrupt requests from peripherals |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 mask, 1 raw status, 2 set bit, 3 clear bit |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| take | input | 1 | One-cycle strobe requesting a selection |
| irq_out | output | 1 | OR of all pending sources |
| sel_valid | output | 1 | Last take found a pending source |
| sel_index | output | 5 | Index chosen by the last successful take |

## Verification
The bench targets the wrap of the search from index 31 back to 0. A design that fails to wrap would return nothing, or the wrong index, after serving the top source.

It also issues a take while nothing is pending and then checks the next pick. A design that resets or advances the pointer on an empty take would choose a lower source than the rotation allows.

Single-bit set and clear operations and writes to the read-only status address are checked for collateral damage to the mask. A full 32-take sweep with every source asserted shows whether any source is skipped or served twice, which is what a fixed-priority or off-by-one pointer would do.

// File: rtl/rr_irq_pkg.sv
package rr_irq_pkg;

    localparam int NUM_SRC = 32;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef enum logic [1:0] {
        REG_MASK   = 2'b00,
        REG_STATUS = 2'b01,
        REG_SETBIT = 2'b10,
        REG_CLRBIT = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } grant_t;

    // Returns a vector with only the addressed bit set.
    function automatic logic [NUM_SRC-1:0] bit_of(input logic [IDX_W-1:0] idx);
        logic [NUM_SRC-1:0] v;
        v      = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rr_mask_regs.sv
module rr_mask_regs
    import rr_irq_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = IDX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  reg_sel_e     sel,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic [N-1:0] rdata
);

    logic [W-1:0] bit_idx;
    assign bit_idx = wdata[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (wr) begin
            unique case (sel)
                REG_MASK:   mask <= wdata;
                REG_SETBIT: mask <= mask | bit_of(bit_idx);
                REG_CLRBIT: mask <= mask & ~bit_of(bit_idx);
                default:    mask <= mask;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_MASK:   rdata = mask;
            REG_STATUS: rdata = raw;
            default:    rdata = '0;
        endcase
    end

    // R9
    setbit_only_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_SETBIT) |=>
            mask[$past(bit_idx)] &&
            ((mask & ~bit_of($past(bit_idx))) == ($past(mask) & ~bit_of($past(bit_idx)))));

    // R9
    clrbit_only_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_CLRBIT) |=>
            !mask[$past(bit_idx)] &&
            ((mask & ~bit_of($past(bit_idx))) == ($past(mask) & ~bit_of($past(bit_idx)))));

    // R8
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == REG_STATUS) |=> $stable(mask));

endmodule

// File: rtl/rr_rotate_finder.sv
module rr_rotate_finder
    import rr_irq_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = IDX_W
) (
    input  logic [N-1:0] pend,
    input  logic [W-1:0] start,
    output logic         hit,
    output logic [W-1:0] hit_idx
);

    // Walk from start upward; W-bit addition wraps modulo N (N is 2**W).
    logic [W-1:0] probe;

    always_comb begin
        hit     = 1'b0;
        hit_idx = start;
        probe   = start;
        for (int k = 0; k < N; k++) begin
            probe = start + W'(k);
            if (!hit && pend[probe]) begin
                hit     = 1'b1;
                hit_idx = probe;
            end
        end
    end

endmodule

// File: rtl/rr_grant_ctrl.sv
module rr_grant_ctrl
    import rr_irq_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = IDX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic [N-1:0] pend,
    input  logic         hit,
    input  logic [W-1:0] hit_idx,
    output logic [W-1:0] ptr,
    output grant_t       grant
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            grant <= '0;
        end else if (take) begin
            if (hit) begin
                grant.valid <= 1'b1;
                grant.idx   <= hit_idx;
                ptr         <= hit_idx + 1'b1;
            end else begin
                grant.valid <= 1'b0;
            end
        end
    end

    // R3
    pick_is_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (take && hit) |-> pend[hit_idx]);

    // R3
    pick_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        (take && pend[ptr]) |-> (hit_idx == ptr));

    // R4
    ptr_past_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (take && hit) |=> (ptr == grant.idx + 1'b1) && grant.valid);

    // R5
    empty_take_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !(|pend)) |=> !grant.valid && $stable(ptr) && $stable(grant.idx));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(ptr) && $stable(grant));

endmodule

// File: rtl/rr_irq_selector.sv
module rr_irq_selector
    import rr_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic               take,
    output logic               irq_out,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_index
);

    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] pend;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   ptr;
    grant_t             grant;

    rr_mask_regs #(.N(NUM_SRC), .W(IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .sel   (reg_sel_e'(reg_addr)),
        .wdata (reg_wdata),
        .raw   (irq_src),
        .mask  (mask),
        .rdata (reg_rdata)
    );

    assign pend    = irq_src & mask;
    assign irq_out = |pend;

    rr_rotate_finder #(.N(NUM_SRC), .W(IDX_W)) u_find (
        .pend    (pend),
        .start   (ptr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    rr_grant_ctrl #(.N(NUM_SRC), .W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .pend    (pend),
        .hit     (hit),
        .hit_idx (hit_idx),
        .ptr     (ptr),
        .grant   (grant)
    );

    assign sel_valid = grant.valid;
    assign sel_index = grant.idx;

    // R1
    irq_matches_finder_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out == hit);

endmodule

// File: tb/test_rr_irq_selector.sv
module test_rr_irq_selector;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_src = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'b00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        take = 1'b0;
    logic        irq_out;
    logic        sel_valid;
    logic [4:0]  sel_index;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state.
    bit [31:0] m_mask;
    int        m_ptr;
    bit        m_valid;
    int        m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    rr_irq_selector i_rr_irq_selector (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq_src),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .take      (take),
        .irq_out   (irq_out),
        .sel_valid (sel_valid),
        .sel_index (sel_index)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: advances on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_mask = '0; m_ptr = 0; m_valid = 1'b0; m_idx = 0;
        end else begin
            bit [31:0] pv;
            pv = irq_src & m_mask;
            if (take) begin
                if (pv == 0) begin
                    m_valid = 1'b0;
                end else begin
                    for (int k = 0; k < 32; k++) begin
                        int j;
                        j = (m_ptr + k) % 32;
                        if (pv[j]) begin
                            m_idx = j; m_valid = 1'b1; m_ptr = (j + 1) % 32;
                            break;
                        end
                    end
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'b00: m_mask = reg_wdata;
                    2'b10: m_mask[reg_wdata[4:0]] = 1'b1;
                    2'b11: m_mask[reg_wdata[4:0]] = 1'b0;
                    default: ;
                endcase
            end
            started = 1'b1;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !rst) begin
            bit [31:0] exp_rd;
            exp_rd = (reg_addr == 2'b00) ? m_mask : (reg_addr == 2'b01) ? irq_src : 32'h0;
            check(irq_out == |(irq_src & m_mask), "R1", irq_out, |(irq_src & m_mask));
            check(sel_valid == m_valid, "R3", sel_valid, m_valid);
            if (m_valid)
                check(sel_index == m_idx[4:0], "R3", sel_index, m_idx);
            check(reg_rdata == exp_rd, "R7", reg_rdata, exp_rd);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic do_take();
        take = 1'b1;
        tick();
        take = 1'b0;
    endtask

    task automatic read_expect(input logic [1:0] a, input logic [31:0] exp, input string req);
        reg_addr = a; #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [31:0] seen;
        bit        dup;
        tick(); tick();
        rst = 1'b0;
        // R2 reset state
        check(sel_valid == 1'b0, "R2", sel_valid, 0);
        check(sel_index == 5'd0, "R2", sel_index, 0);
        read_expect(2'b00, 32'h0, "R2");

        // R3 / R4 rotation and wrap
        wr_reg(2'b00, 32'hFFFF_FFFF);
        irq_src = 32'h8000_0011;
        do_take(); check(sel_index == 5'd0 && sel_valid, "R3", sel_index, 0);
        do_take(); check(sel_index == 5'd4, "R3", sel_index, 4);
        do_take(); check(sel_index == 5'd31, "R3", sel_index, 31);
        do_take(); check(sel_index == 5'd0, "R4", sel_index, 0);

        // R5 empty take keeps pointer at 1
        irq_src = 32'h0;
        do_take();
        check(sel_valid == 1'b0, "R5", sel_valid, 0);
        check(sel_index == 5'd0, "R5", sel_index, 0);
        irq_src = 32'h0000_0009;
        do_take(); check(sel_index == 5'd3 && sel_valid, "R5", sel_index, 3);

        // R6 no take: hold
        irq_src = 32'h0000_0100;
        tick(); tick(); tick();
        check(sel_index == 5'd3 && sel_valid, "R6", sel_index, 3);

        // R1 mask gating
        wr_reg(2'b00, 32'h0000_00F0);
        irq_src = 32'h0000_000F; #1;
        check(irq_out == 1'b0, "R1", irq_out, 0);
        irq_src = 32'h0000_0010; #1;
        check(irq_out == 1'b1, "R1", irq_out, 1);

        // R9 single-bit set and clear
        wr_reg(2'b10, 32'd0);
        read_expect(2'b00, 32'h0000_00F1, "R9");
        wr_reg(2'b11, 32'd4);
        read_expect(2'b00, 32'h0000_00E1, "R9");
        read_expect(2'b10, 32'h0, "R9");

        // R8 status readback, status write ignored
        wr_reg(2'b01, 32'h1234_5678);
        read_expect(2'b00, 32'h0000_00E1, "R8");
        irq_src = 32'hA5A5_0000;
        read_expect(2'b01, 32'hA5A5_0000, "R8");

        // R10 full sweep
        wr_reg(2'b00, 32'hFFFF_FFFF);
        irq_src = 32'hFFFF_FFFF;
        seen = '0; dup = 1'b0;
        for (int n = 0; n < 32; n++) begin
            do_take();
            if (seen[sel_index]) dup = 1'b1;
            seen[sel_index] = 1'b1;
        end
        check(seen == 32'hFFFF_FFFF && !dup, "R10", seen, 32'hFFFF_FFFF);

        // Mixed random traffic, compared per cycle against the model
        reg_addr = 2'b00;
        for (int n = 0; n < 400; n++) begin
            irq_src = $urandom() & $urandom();
            if (($urandom() % 5) == 0) begin
                reg_wr = 1'b1;
                reg_addr = 2'($urandom());
                reg_wdata = $urandom();
            end else begin
                reg_wr = 1'b0;
            end
            take = ($urandom() % 2) == 1;
            tick();
        end
        reg_wr = 1'b0; take = 1'b0;
        tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule